// File: doc/BRIEF.md
# Walsh-Hadamard Boolean Coefficient Engine

This block takes the complete truth table of a Boolean function of `NVAR` inputs and produces its 2^NVAR Walsh-Hadamard coefficients. Each coefficient gives the weight of one basis function in the function's expansion. The basis functions are the constant 1 and the product of every distinct subset of the inputs. The table is first recoded into bipolar form, with a one read as +1 and a zero read as -1. An in-place butterfly then runs on a register array, one stage of paired sums and differences per clock, until every input bit has been folded in.

A single-cycle `start` captures the table. The `done` output then rises `NVAR` clocks later. The coefficients are presented as signed integers without the 1/2^NVAR normalisation, and the consumer applies that scale. The results stay on the port until the next accepted start. This lets a downstream unit read them at its own pace, for example to pick the monomials that carry a threshold network.

Top module: `whc_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge state is `busy`=0, `done`=0 and every coefficient equal to zero.
- R2: A `start` seen while `busy` is low loads the table. `busy` is high from the next clock, and `done` rises, with `busy` falling on the same edge, exactly `NVAR` clocks after the loading edge. `busy` and `done` are never high together.
- R3: Bit j of `truth_tbl` is the function value when input x(i+1) equals bit i of j. Coefficient k sits at `coef[k*W +: W]`, in two's complement with W = NVAR+2. Its value is the sum over all j of b(j) times the product, over every bit i set in k, of (+1 if bit i of j is 1, else -1). Here b(j) is +1 for a true entry and -1 for a false one.
- R4: With `NVAR`=2, the two-input AND table 4'b1000 gives coefficients (constant, x1, x2, x1·x2) = (-2, 2, 2, 2). OR (4'b1110) gives (2, 2, 2, -2), and XOR (4'b0110) gives (0, 0, 0, -4).
- R5: A `start` pulse while `busy` is high has no effect. The pending result belongs to the table loaded first, and its `done` timing is unchanged.
- R6: Once `done` is high, it and all coefficients hold steady until a new `start`. That `start` clears `done` at the next edge and begins a fresh run.
- R7: Whenever `done` is high, the squares of all coefficients add up to 4^NVAR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture `truth_tbl` and begin a transform when idle |
| truth_tbl | input | 2^NVAR | Function value for each input combination, bit j for input pattern j |
| busy | output | 1 | Butterfly stages in progress |
| done | output | 1 | Coefficients valid and held |
| coef | output | 2^NVAR·(NVAR+2) | Unscaled signed coefficients, coefficient k at slice k |

## Verification
The bench builds two copies of the engine. The first uses `NVAR`=3, which gives three butterfly stages with strides 1, 2 and 4, so the cross-stride indexing and the three-way products are exercised. On this copy, AND, OR, XOR, constant and arbitrary tables are compared each clock against a direct matrix product, including a start issued mid-run and a restart issued from the held state. The second copy uses `NVAR`=2, which brings the small two-input cases into reach and checks them against the fixed values stated in R4.

// File: rtl/whc_pkg.sv
package whc_pkg;

    typedef enum logic [1:0] {
        WHC_IDLE = 2'd0,
        WHC_RUN  = 2'd1,
        WHC_HOLD = 2'd2
    } whc_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } whc_ctl_t;

    function automatic int unsigned whc_idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/whc_seq.sv
module whc_seq
    import whc_pkg::*;
#(
    parameter int unsigned NVAR = 3,
    localparam int unsigned SW = whc_idx_bits(NVAR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output whc_ctl_t      ctl,
    output logic [SW-1:0] stage,
    output logic          busy,
    output logic          done
);

    whc_state_e    st_q;
    logic [SW-1:0] stage_q;
    logic          last_stage;

    assign last_stage = (stage_q == SW'(NVAR - 1));

    always_comb begin
        ctl.load = start && (st_q != WHC_RUN);
        ctl.step = (st_q == WHC_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WHC_IDLE;
            stage_q <= '0;
        end else if (ctl.load) begin
            st_q    <= WHC_RUN;
            stage_q <= '0;
        end else if (st_q == WHC_RUN) begin
            if (last_stage) begin
                st_q    <= WHC_HOLD;
                stage_q <= '0;
            end else begin
                stage_q <= stage_q + 1'b1;
            end
        end
    end

    assign stage = stage_q;
    assign busy  = (st_q == WHC_RUN);
    assign done  = (st_q == WHC_HOLD);

endmodule

// File: rtl/whc_bfly.sv
module whc_bfly
    import whc_pkg::*;
#(
    parameter int unsigned NVAR = 3,
    parameter int unsigned W    = NVAR + 2,
    localparam int unsigned NE  = 1 << NVAR,
    localparam int unsigned SW  = whc_idx_bits(NVAR)
) (
    input  logic [NE*W-1:0] vals_i,
    input  logic [SW-1:0]   stage,
    output logic [NE*W-1:0] vals_o
);

    logic signed [W-1:0] cand [NVAR][NE];

    for (genvar s = 0; s < NVAR; s++) begin : g_stage
        localparam int unsigned HB = 1 << s;
        for (genvar j = 0; j < NE; j++) begin : g_elem
            localparam int unsigned PJ = j ^ HB;
            if ((j & HB) == 0) begin : g_lo
                assign cand[s][j] = $signed(vals_i[j*W +: W]) + $signed(vals_i[PJ*W +: W]);
            end else begin : g_hi
                assign cand[s][j] = $signed(vals_i[j*W +: W]) - $signed(vals_i[PJ*W +: W]);
            end
        end
    end

    always_comb begin
        vals_o = vals_i;
        for (int s = 0; s < NVAR; s++) begin
            if (stage == SW'(s)) begin
                for (int j = 0; j < NE; j++) begin
                    vals_o[j*W +: W] = cand[s][j];
                end
            end
        end
    end

endmodule

// File: rtl/whc_engine.sv
module whc_engine
    import whc_pkg::*;
#(
    parameter int unsigned NVAR = 3,
    localparam int unsigned W  = NVAR + 2,
    localparam int unsigned NE = 1 << NVAR,
    localparam int unsigned SW = whc_idx_bits(NVAR)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [NE-1:0]  truth_tbl,
    output logic           busy,
    output logic           done,
    output logic [NE*W-1:0] coef
);

    whc_ctl_t       ctl;
    logic [SW-1:0]  stage;
    logic [NE*W-1:0] arr_q;
    logic [NE*W-1:0] arr_nx;
    logic [NE*W-1:0] bipolar;

    whc_seq #(.NVAR(NVAR)) seq_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .stage (stage),
        .busy  (busy),
        .done  (done)
    );

    whc_bfly #(.NVAR(NVAR), .W(W)) bfly_i (
        .vals_i (arr_q),
        .stage  (stage),
        .vals_o (arr_nx)
    );

    for (genvar j = 0; j < NE; j++) begin : g_bip
        assign bipolar[j*W +: W] = {{(W-1){~truth_tbl[j]}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q <= '0;
        end else if (ctl.load) begin
            arr_q <= bipolar;
        end else if (ctl.step) begin
            arr_q <= arr_nx;
        end
    end

    assign coef = arr_q;

endmodule

// File: rtl/whc_engine_chk.sv
module whc_engine_chk #(
    parameter int unsigned NVAR = 3,
    localparam int unsigned W  = NVAR + 2,
    localparam int unsigned NE = 1 << NVAR
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [NE*W-1:0] coef
);

    int unsigned run_cnt;
    int          sumsq;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (start && !busy) begin
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    always_comb begin
        int v;
        sumsq = 0;
        for (int k = 0; k < NE; k++) begin
            v = int'($signed(coef[k*W +: W]));
            sumsq = sumsq + v * v;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done && coef == '0)); // R1
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> (run_cnt == NVAR)); // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start && run_cnt < NVAR - 1) |=> busy); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> (done && $stable(coef))); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst) (done && start) |=> (!done && busy)); // R6
    AST_ENERGY: assert property (@(posedge clk) disable iff (rst) done |-> (sumsq == (1 << (2 * NVAR)))); // R7

endmodule

bind whc_engine whc_engine_chk #(.NVAR(NVAR)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .coef  (coef)
);

// File: tb/whc_engine_tb_top.sv
module whc_engine_tb_top;

    localparam int CLK_P = 10;
    localparam int N  = 3;
    localparam int W  = N + 2;
    localparam int NE = 1 << N;
    localparam int N2 = 2;
    localparam int W2 = N2 + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NE-1:0] tt = '0;
    logic busy, done;
    logic [NE*W-1:0] coef;

    logic start2 = 1'b0;
    logic [3:0] tt2 = '0;
    logic busy2, done2;
    logic [4*W2-1:0] coef2;

    int n_chk = 0;
    int n_bad = 0;

    int m_busy = 0, m_done = 0, m_cnt = 0;
    logic [NE-1:0] m_tt = '0;

    always #(CLK_P/2) clk = ~clk;

    whc_engine #(.NVAR(N)) dut_i (
        .clk(clk), .rst(rst), .start(start), .truth_tbl(tt),
        .busy(busy), .done(done), .coef(coef)
    );

    whc_engine #(.NVAR(N2)) dut2_i (
        .clk(clk), .rst(rst), .start(start2), .truth_tbl(tt2),
        .busy(busy2), .done(done2), .coef(coef2)
    );

    function automatic int refc(input int n, input logic [31:0] t, input int k);
        int s = 0;
        for (int j = 0; j < (1 << n); j++) begin
            int p = t[j] ? 1 : -1;
            for (int i = 0; i < n; i++) begin
                if (k[i]) p = p * (j[i] ? 1 : -1);
            end
            s = s + p;
        end
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_busy = 0; m_done = 0;
        end else if (start && !m_busy) begin
            m_busy = 1; m_done = 0; m_cnt = 0; m_tt = tt;
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == N) begin m_busy = 0; m_done = 1; end
        end
        @(negedge clk);
        check("R2 busy", int'(busy), m_busy);
        check("R2 done", int'(done), m_done);
        if (m_done) begin
            int sq = 0;
            for (int k = 0; k < NE; k++) begin
                int v = int'($signed(coef[k*W +: W]));
                check("R3/R5/R6 coef", v, refc(N, 32'(m_tt), k));
                sq += v * v;
            end
            check("R7 energy", sq, 1 << (2 * N));
        end
    endtask

    task automatic run_tt(input logic [NE-1:0] t);
        tt = t; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (N + 2) tick();
    endtask

    task automatic run2(input logic [3:0] t, input int e0, input int e1, input int e2, input int e3);
        tt2 = t; start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        repeat (N2) @(negedge clk);
        check("R4 done", int'(done2), 1);
        check("R4 c0", int'($signed(coef2[0*W2 +: W2])), e0);
        check("R4 c1", int'($signed(coef2[1*W2 +: W2])), e1);
        check("R4 c2", int'($signed(coef2[2*W2 +: W2])), e2);
        check("R4 c3", int'($signed(coef2[3*W2 +: W2])), e3);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tt = 8'hA5; start = 1'b1;
        tick(); tick();
        // R1: reset state, start held during reset has no effect
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 coef", (coef == '0) ? 1 : 0, 1);
        start = 1'b0;
        rst = 1'b0;
        tick();
        // R3: AND, OR, XOR, constants and arbitrary tables
        run_tt(8'h80);
        run_tt(8'hFE);
        run_tt(8'h96);
        run_tt(8'h00);
        run_tt(8'hFF);
        run_tt(8'h5C);
        run_tt(8'h3A);
        // R5: start mid-run with another table is ignored
        tt = 8'h17; start = 1'b1; tick();
        tt = 8'hE9; tick();
        start = 1'b0; tt = 8'h00;
        repeat (N + 2) tick();
        // R6: restart directly from held result
        check("R6 held done", int'(done), 1);
        run_tt(8'h69);
        // R4: two-input cases on the smaller engine
        run2(4'b1000, -2, 2, 2, 2);
        run2(4'b1110, 2, 2, 2, -2);
        run2(4'b0110, 0, 0, 0, -4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule